// File: doc/BRIEF.md
# Capability Trap-Vector and Exception-PC Legalizer

This block owns the two special capability registers that steer control transfer on exceptions: the trap vector, which names where a handler starts, and the exception PC, which records where a trapped program resumes. Every software write to either register is made legal before it is stored. Low address bits that cannot hold a valid target are cleared, and any such correction also removes the tag. A value that is sealed or not executable is stored with its tag removed. Only direct-mode trap vectors exist.

On a trap the block saves the current program-counter capability into the exception-PC register and loads the program-counter capability from the trap vector. On a return from machine mode it loads the program-counter capability from the exception-PC register. It also packs the trap's cause fields into a cause word. If the new program-counter capability has no tag, the block reports a tag-violation fault with the capability exception code and a cause word that points at the program-counter capability. With an untagged trap vector this fault comes back on every trap, so the fault loop never ends.

Top module: `cap_trap_legalizer`

## Requirements
- R1: A trap-vector write (wr_sel_i = 0) stores the address with bits [1:0] cleared. If either of those bits was set, the stored tag is 0.
- R2: An exception-PC write (wr_sel_i = 1) stores the address with bit 0 cleared and bit 1 kept. If bit 0 was set, the stored tag is 0.
- R3: For either register, the stored tag is 0 when wr_sealed_i is 1 or wr_exec_i is 0.
- R4: A legal write (tagged, unsealed, executable, aligned) is stored unchanged. rd_addr_o/rd_tag_o show the stored value from the first rising edge after the write (rd_sel_i: 0 = trap vector, 1 = exception PC).
- R5: A trap_i pulse makes redirect_o 1 for the following cycle. pcc_addr_o/pcc_tag_o then carry the trap vector as it was before the edge, and the exception PC is loaded with cur_pcc_addr_i (bit 0 cleared) and cur_pcc_tag_i.
- R6: An mret_i pulse without trap_i makes redirect_o 1 for the following cycle, with pcc_addr_o/pcc_tag_o set to the exception PC as it was before the edge.
- R7: When the new program-counter capability is untagged, fault_o is 1 in the redirect cycle. In that cycle fault_code_o = 0x1C and fault_mtval_o = 0x402 (cause 0x02, index 0, S = 1). Otherwise fault_o, fault_code_o and fault_mtval_o are 0. This repeats on every trap taken through an untagged vector.
- R8: trap_mtval_o, loaded on each trap, carries trap_cause_i in bits [4:0], trap_idx_i in bits [9:5] and trap_s_i in bit 10, with bits [31:11] zero.
- R9: A trap in the same cycle as an exception-PC write stores the saved program counter, and the write is lost. A trap in the same cycle as a trap-vector write redirects to the old vector, and the write is stored.
- R10: When trap_i and mret_i are both 1, the trap is taken and the return is ignored.
- R11: After reset both registers read address 0 with tag 0, and redirect_o, fault_o, pcc_addr_o, pcc_tag_o and trap_mtval_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Special register write strobe |
| wr_sel_i | input | 1 | Write target: 0 trap vector, 1 exception PC |
| wr_addr_i | input | 32 | Address field of the written capability |
| wr_tag_i | input | 1 | Tag of the written capability |
| wr_sealed_i | input | 1 | Written capability is sealed |
| wr_exec_i | input | 1 | Written capability has execute permission |
| rd_sel_i | input | 1 | Read select: 0 trap vector, 1 exception PC |
| rd_addr_o | output | 32 | Stored address of the selected register |
| rd_tag_o | output | 1 | Stored tag of the selected register |
| trap_i | input | 1 | Trap entry strobe |
| trap_cause_i | input | 5 | Capability cause code of the trap |
| trap_idx_i | input | 5 | Faulting register index |
| trap_s_i | input | 1 | Index names a special register |
| cur_pcc_addr_i | input | 32 | Address of the current program-counter capability |
| cur_pcc_tag_i | input | 1 | Tag of the current program-counter capability |
| mret_i | input | 1 | Return-from-trap strobe |
| redirect_o | output | 1 | New program-counter capability valid this cycle |
| pcc_addr_o | output | 32 | New program-counter address |
| pcc_tag_o | output | 1 | New program-counter tag |
| fault_o | output | 1 | Tag violation on the new program counter |
| fault_code_o | output | 6 | Exception code of the fault |
| fault_mtval_o | output | 32 | Cause word of the fault |
| trap_mtval_o | output | 32 | Cause word of the last trap |

## Verification
Two pairs of functions can fall in the same cycle. A software write to a special register can meet a trap that reads or saves that register, and a trap can meet a return. The bench drives a trap together with a write to each register in turn. Afterwards it reads the register back and compares both the redirect target and the stored value against the precedence in R9. It also raises trap_i and mret_i together and checks that the redirect target is the trap vector and not the exception PC.

// File: rtl/cap_trap_pkg.sv
package cap_trap_pkg;
  localparam int MTVAL_W = 32;
  localparam int CAUSE_W = 5;
  localparam int IDX_W   = 5;
  localparam int EXC_W   = 6;
  localparam int S_POS   = CAUSE_W + IDX_W;
  localparam int NUM_SCR = 2;

  localparam logic [EXC_W-1:0]   CAP_EXC_CODE = EXC_W'(6'h1C);
  localparam logic [CAUSE_W-1:0] CAUSE_TAG    = CAUSE_W'(5'h02);

  typedef enum logic {SCR_VEC = 1'b0, SCR_EPC = 1'b1} scr_sel_e;

  function automatic logic [MTVAL_W-1:0] pack_mtval(
      input logic [CAUSE_W-1:0] cause, input logic [IDX_W-1:0] idx, input logic s);
    logic [MTVAL_W-1:0] w;
    w = '0;
    w[CAUSE_W-1:0]       = cause;
    w[S_POS-1:CAUSE_W]   = idx;
    w[S_POS]             = s;
    return w;
  endfunction
endpackage

// File: rtl/cap_scr_legalize.sv
module cap_scr_legalize #(
  parameter int ADDR_W   = 32,
  parameter int LOW_BITS = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              tag_i,
  input  logic              sealed_i,
  input  logic              exec_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              tag_o
);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << LOW_BITS) - 1);

  logic misaligned;

  always_comb begin
    misaligned = |(addr_i & LOW_MASK);
    addr_o     = addr_i & ~LOW_MASK;
    tag_o      = tag_i & ~sealed_i & exec_i & ~misaligned;
  end
endmodule

// File: rtl/cap_scr_bank.sv
module cap_scr_bank
  import cap_trap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_tag_i,
  input  logic              wr_sealed_i,
  input  logic              wr_exec_i,
  input  logic              save_en_i,
  input  logic [ADDR_W-1:0] save_addr_i,
  input  logic              save_tag_i,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              vec_tag_o,
  output logic [ADDR_W-1:0] epc_addr_o,
  output logic              epc_tag_o
);
  logic [ADDR_W-1:0] addr_q [NUM_SCR];
  logic              tag_q  [NUM_SCR];

  for (genvar g = 0; g < NUM_SCR; g++) begin : g_scr
    localparam int LB = (g == int'(SCR_VEC)) ? 2 : 1;
    logic [ADDR_W-1:0] leg_addr;
    logic              leg_tag;
    logic              wr_hit;

    cap_scr_legalize #(.ADDR_W(ADDR_W), .LOW_BITS(LB)) u_leg (
      .addr_i  (wr_addr_i),
      .tag_i   (wr_tag_i),
      .sealed_i(wr_sealed_i),
      .exec_i  (wr_exec_i),
      .addr_o  (leg_addr),
      .tag_o   (leg_tag)
    );

    assign wr_hit = wr_en_i && (wr_sel_i == 1'(g));

    if (g == int'(SCR_EPC)) begin : g_epc
      // hardware save on trap beats a software write
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          addr_q[g] <= '0;
          tag_q[g]  <= 1'b0;
        end else if (save_en_i) begin
          addr_q[g] <= save_addr_i;
          tag_q[g]  <= save_tag_i;
        end else if (wr_hit) begin
          addr_q[g] <= leg_addr;
          tag_q[g]  <= leg_tag;
        end
      end
    end else begin : g_vec
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          addr_q[g] <= '0;
          tag_q[g]  <= 1'b0;
        end else if (wr_hit) begin
          addr_q[g] <= leg_addr;
          tag_q[g]  <= leg_tag;
        end
      end
    end
  end

  assign vec_addr_o = addr_q[SCR_VEC];
  assign vec_tag_o  = tag_q[SCR_VEC];
  assign epc_addr_o = addr_q[SCR_EPC];
  assign epc_tag_o  = tag_q[SCR_EPC];
endmodule

// File: rtl/cap_pcc_ctrl.sv
module cap_pcc_ctrl
  import cap_trap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trap_i,
  input  logic               mret_i,
  input  logic [CAUSE_W-1:0] trap_cause_i,
  input  logic [IDX_W-1:0]   trap_idx_i,
  input  logic               trap_s_i,
  input  logic [ADDR_W-1:0]  cur_pcc_addr_i,
  input  logic               cur_pcc_tag_i,
  input  logic [ADDR_W-1:0]  vec_addr_i,
  input  logic               vec_tag_i,
  input  logic [ADDR_W-1:0]  epc_addr_i,
  input  logic               epc_tag_i,
  output logic               save_en_o,
  output logic [ADDR_W-1:0]  save_addr_o,
  output logic               save_tag_o,
  output logic               redirect_o,
  output logic [ADDR_W-1:0]  pcc_addr_o,
  output logic               pcc_tag_o,
  output logic               fault_o,
  output logic [EXC_W-1:0]   fault_code_o,
  output logic [MTVAL_W-1:0] fault_mtval_o,
  output logic [MTVAL_W-1:0] trap_mtval_o
);
  localparam logic [MTVAL_W-1:0] PCC_FAULT_WORD = pack_mtval(CAUSE_TAG, '0, 1'b1);

  logic               redirect_q, fault_q, pcc_tag_q;
  logic [ADDR_W-1:0]  pcc_addr_q;
  logic [MTVAL_W-1:0] mtval_q;
  logic               take_ret;

  assign take_ret    = mret_i && !trap_i;
  assign save_en_o   = trap_i;
  assign save_addr_o = {cur_pcc_addr_i[ADDR_W-1:1], 1'b0};
  assign save_tag_o  = cur_pcc_tag_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_q <= 1'b0;
      fault_q    <= 1'b0;
      pcc_addr_q <= '0;
      pcc_tag_q  <= 1'b0;
      mtval_q    <= '0;
    end else if (trap_i) begin
      redirect_q <= 1'b1;
      pcc_addr_q <= vec_addr_i;
      pcc_tag_q  <= vec_tag_i;
      fault_q    <= !vec_tag_i;
      mtval_q    <= pack_mtval(trap_cause_i, trap_idx_i, trap_s_i);
    end else if (take_ret) begin
      redirect_q <= 1'b1;
      pcc_addr_q <= epc_addr_i;
      pcc_tag_q  <= epc_tag_i;
      fault_q    <= !epc_tag_i;
    end else begin
      redirect_q <= 1'b0;
      fault_q    <= 1'b0;
    end
  end

  assign redirect_o    = redirect_q;
  assign pcc_addr_o    = pcc_addr_q;
  assign pcc_tag_o     = pcc_tag_q;
  assign fault_o       = fault_q;
  assign fault_code_o  = fault_q ? CAP_EXC_CODE : '0;
  assign fault_mtval_o = fault_q ? PCC_FAULT_WORD : '0;
  assign trap_mtval_o  = mtval_q;
endmodule

// File: rtl/cap_trap_legalizer.sv
module cap_trap_legalizer
  import cap_trap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               wr_sel_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic               wr_tag_i,
  input  logic               wr_sealed_i,
  input  logic               wr_exec_i,
  input  logic               rd_sel_i,
  output logic [ADDR_W-1:0]  rd_addr_o,
  output logic               rd_tag_o,
  input  logic               trap_i,
  input  logic [CAUSE_W-1:0] trap_cause_i,
  input  logic [IDX_W-1:0]   trap_idx_i,
  input  logic               trap_s_i,
  input  logic [ADDR_W-1:0]  cur_pcc_addr_i,
  input  logic               cur_pcc_tag_i,
  input  logic               mret_i,
  output logic               redirect_o,
  output logic [ADDR_W-1:0]  pcc_addr_o,
  output logic               pcc_tag_o,
  output logic               fault_o,
  output logic [EXC_W-1:0]   fault_code_o,
  output logic [MTVAL_W-1:0] fault_mtval_o,
  output logic [MTVAL_W-1:0] trap_mtval_o
);
  logic [ADDR_W-1:0] vec_addr, epc_addr, save_addr;
  logic              vec_tag, epc_tag, save_tag, save_en;

  cap_scr_bank #(.ADDR_W(ADDR_W)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_addr_i   (wr_addr_i),
    .wr_tag_i    (wr_tag_i),
    .wr_sealed_i (wr_sealed_i),
    .wr_exec_i   (wr_exec_i),
    .save_en_i   (save_en),
    .save_addr_i (save_addr),
    .save_tag_i  (save_tag),
    .vec_addr_o  (vec_addr),
    .vec_tag_o   (vec_tag),
    .epc_addr_o  (epc_addr),
    .epc_tag_o   (epc_tag)
  );

  cap_pcc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .trap_i         (trap_i),
    .mret_i         (mret_i),
    .trap_cause_i   (trap_cause_i),
    .trap_idx_i     (trap_idx_i),
    .trap_s_i       (trap_s_i),
    .cur_pcc_addr_i (cur_pcc_addr_i),
    .cur_pcc_tag_i  (cur_pcc_tag_i),
    .vec_addr_i     (vec_addr),
    .vec_tag_i      (vec_tag),
    .epc_addr_i     (epc_addr),
    .epc_tag_i      (epc_tag),
    .save_en_o      (save_en),
    .save_addr_o    (save_addr),
    .save_tag_o     (save_tag),
    .redirect_o     (redirect_o),
    .pcc_addr_o     (pcc_addr_o),
    .pcc_tag_o      (pcc_tag_o),
    .fault_o        (fault_o),
    .fault_code_o   (fault_code_o),
    .fault_mtval_o  (fault_mtval_o),
    .trap_mtval_o   (trap_mtval_o)
  );

  assign rd_addr_o = (rd_sel_i == SCR_EPC) ? epc_addr : vec_addr;
  assign rd_tag_o  = (rd_sel_i == SCR_EPC) ? epc_tag  : vec_tag;
endmodule

// File: rtl/cap_trap_legalizer_chk.sv
module cap_trap_legalizer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              trap_i,
  input logic              mret_i,
  input logic [ADDR_W-1:0] cur_pcc_addr_i,
  input logic              cur_pcc_tag_i,
  input logic [ADDR_W-1:0] vec_addr,
  input logic              vec_tag,
  input logic [ADDR_W-1:0] epc_addr,
  input logic              epc_tag,
  input logic              redirect_o,
  input logic [ADDR_W-1:0] pcc_addr_o,
  input logic              pcc_tag_o,
  input logic              fault_o,
  input logic [5:0]        fault_code_o,
  input logic [31:0]       trap_mtval_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_VEC_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_addr[1:0] == 2'b00); // R1
  AST_EPC_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epc_addr[0] == 1'b0); // R2
  AST_TRAP_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(trap_i) |-> redirect_o && pcc_addr_o == $past(vec_addr)
                                 && pcc_tag_o == $past(vec_tag)); // R5
  AST_TRAP_SAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(trap_i) |-> epc_addr == ($past(cur_pcc_addr_i) & ~ADDR_W'(1))
                                 && epc_tag == $past(cur_pcc_tag_i)); // R5
  AST_RET_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(mret_i) && !$past(trap_i) |-> redirect_o
      && pcc_addr_o == $past(epc_addr) && pcc_tag_o == $past(epc_tag)); // R6
  AST_FAULT_UNTAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> redirect_o && !pcc_tag_o && fault_code_o == 6'h1C); // R7
  AST_NO_IDLE_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(trap_i) && !$past(mret_i) |-> !redirect_o && !fault_o); // R6
  AST_MTVAL_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_mtval_o[31:11] == '0); // R8
endmodule

bind cap_trap_legalizer cap_trap_legalizer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .trap_i         (trap_i),
  .mret_i         (mret_i),
  .cur_pcc_addr_i (cur_pcc_addr_i),
  .cur_pcc_tag_i  (cur_pcc_tag_i),
  .vec_addr       (vec_addr),
  .vec_tag        (vec_tag),
  .epc_addr       (epc_addr),
  .epc_tag        (epc_tag),
  .redirect_o     (redirect_o),
  .pcc_addr_o     (pcc_addr_o),
  .pcc_tag_o      (pcc_tag_o),
  .fault_o        (fault_o),
  .fault_code_o   (fault_code_o),
  .trap_mtval_o   (trap_mtval_o)
);

// File: tb/cap_trap_legalizer_tb.sv
`timescale 1ns/1ps
module cap_trap_legalizer_tb;
  localparam int K_RD = 0, K_PCC = 1, K_IDLE = 2;

  typedef struct {
    int          cyc;
    int          kind;
    logic [31:0] a;
    logic        t;
    logic        f;
    logic [31:0] mv;
    string       req;
  } exp_t;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        wr_en_i = 0, wr_sel_i = 0, wr_tag_i = 0, wr_sealed_i = 0, wr_exec_i = 0;
  logic [31:0] wr_addr_i = '0, cur_pcc_addr_i = '0;
  logic        rd_sel_i = 0, trap_i = 0, trap_s_i = 0, cur_pcc_tag_i = 0, mret_i = 0;
  logic [4:0]  trap_cause_i = '0, trap_idx_i = '0;
  logic [31:0] rd_addr_o, pcc_addr_o, fault_mtval_o, trap_mtval_o;
  logic        rd_tag_o, redirect_o, pcc_tag_o, fault_o;
  logic [5:0]  fault_code_o;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  cap_trap_legalizer u_dut (.*, .clk_i(clk));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // monitor: compares queued expectations shortly after each rising edge
  always begin
    @(posedge clk);
    cyc++;
    #2;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      case (e.kind)
        K_RD: begin
          chk(rd_addr_o == e.a, e.req, "rd_addr", rd_addr_o, e.a);
          chk(rd_tag_o == e.t, e.req, "rd_tag", 32'(rd_tag_o), 32'(e.t));
        end
        K_PCC: begin
          chk(redirect_o == 1'b1, e.req, "redirect", 32'(redirect_o), 32'd1);
          chk(pcc_addr_o == e.a && pcc_tag_o == e.t, e.req, "pcc",
              {pcc_addr_o[30:0], pcc_tag_o}, {e.a[30:0], e.t});
          chk(fault_o == e.f, e.req, "fault", 32'(fault_o), 32'(e.f));
          chk(fault_code_o == (e.f ? 6'h1C : 6'h00), e.req, "fault_code",
              32'(fault_code_o), e.f ? 32'h1C : 32'h0);
          chk(fault_mtval_o == (e.f ? 32'h402 : 32'h0), e.req, "fault_mtval",
              fault_mtval_o, e.f ? 32'h402 : 32'h0);
          chk(trap_mtval_o == e.mv, e.req, "trap_mtval", trap_mtval_o, e.mv);
        end
        default: begin
          chk(!redirect_o && !fault_o, e.req, "idle redirect/fault",
              {30'd0, redirect_o, fault_o}, 32'd0);
        end
      endcase
    end
  end

  task automatic next_cycle();
    @(negedge clk);
    wr_en_i = 0; trap_i = 0; mret_i = 0; wr_sealed_i = 0;
  endtask

  task automatic set_wr(input logic sel, input logic [31:0] a, input logic t,
                        input logic s, input logic x);
    wr_en_i = 1; wr_sel_i = sel; wr_addr_i = a; wr_tag_i = t; wr_sealed_i = s; wr_exec_i = x;
  endtask

  task automatic set_trap(input logic [31:0] pc, input logic pt, input logic [4:0] c,
                          input logic [4:0] i, input logic s);
    trap_i = 1; cur_pcc_addr_i = pc; cur_pcc_tag_i = pt;
    trap_cause_i = c; trap_idx_i = i; trap_s_i = s;
  endtask

  task automatic exp_rd(input logic sel, input logic [31:0] a, input logic t, input string r);
    exp_t e;
    rd_sel_i = sel;
    e.cyc = cyc + 1; e.kind = K_RD; e.a = a; e.t = t; e.f = 0; e.mv = '0; e.req = r;
    q.push_back(e);
  endtask

  task automatic exp_pcc(input logic [31:0] a, input logic t, input logic f,
                         input logic [31:0] mv, input string r);
    exp_t e;
    e.cyc = cyc + 1; e.kind = K_PCC; e.a = a; e.t = t; e.f = f; e.mv = mv; e.req = r;
    q.push_back(e);
  endtask

  task automatic exp_idle(input string r);
    exp_t e;
    e.cyc = cyc + 1; e.kind = K_IDLE; e.a = '0; e.t = 0; e.f = 0; e.mv = '0; e.req = r;
    q.push_back(e);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] mv_a;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R11 reset state
    chk(rd_addr_o == 0 && rd_tag_o == 0, "R11", "vec after reset", {rd_addr_o[30:0], rd_tag_o}, 0);
    rd_sel_i = 1; #1;
    chk(rd_addr_o == 0 && rd_tag_o == 0, "R11", "epc after reset", {rd_addr_o[30:0], rd_tag_o}, 0);
    chk(!redirect_o && !fault_o && pcc_addr_o == 0 && !pcc_tag_o && trap_mtval_o == 0,
        "R11", "outputs after reset", pcc_addr_o | trap_mtval_o | 32'(redirect_o), 0);

    next_cycle(); set_wr(0, 32'h1000, 1, 0, 1); exp_rd(0, 32'h1000, 1, "R4 legal vec");
    next_cycle(); set_wr(1, 32'h2000, 1, 0, 1); exp_rd(1, 32'h2000, 1, "R4 legal epc");
    next_cycle(); set_wr(0, 32'h1002, 1, 0, 1); exp_rd(0, 32'h1000, 0, "R1 vec bit1");
    next_cycle(); set_wr(0, 32'h1001, 1, 0, 1); exp_rd(0, 32'h1000, 0, "R1 vec bit0");
    next_cycle(); set_wr(1, 32'h2002, 1, 0, 1); exp_rd(1, 32'h2002, 1, "R2 epc bit1 kept");
    next_cycle(); set_wr(1, 32'h2003, 1, 0, 1); exp_rd(1, 32'h2002, 0, "R2 epc bit0");
    next_cycle(); set_wr(0, 32'h3000, 1, 1, 1); exp_rd(0, 32'h3000, 0, "R3 sealed vec");
    next_cycle(); set_wr(1, 32'h4000, 1, 0, 0); exp_rd(1, 32'h4000, 0, "R3 no exec epc");
    next_cycle(); set_wr(1, 32'h4004, 1, 1, 1); exp_rd(1, 32'h4004, 0, "R3 sealed epc");

    // R5 trap with tagged vector, R8 cause word
    next_cycle(); set_wr(0, 32'h8000, 1, 0, 1); exp_rd(0, 32'h8000, 1, "R4 vec setup");
    next_cycle(); set_trap(32'h5005, 1, 5'h03, 5'd7, 0);
    exp_pcc(32'h8000, 1, 0, 32'h0000_00E3, "R5 trap"); exp_rd(1, 32'h5004, 1, "R5 epc save");
    next_cycle(); exp_idle("R5 one-cycle redirect");
    next_cycle(); mret_i = 1; exp_pcc(32'h5004, 1, 0, 32'h0000_00E3, "R6 mret");
    next_cycle(); exp_idle("R6 one-cycle redirect");
    next_cycle(); set_trap(32'h5100, 1, 5'h1F, 5'h1F, 1);
    exp_pcc(32'h8000, 1, 0, 32'h0000_07FF, "R8 all fields");

    // R7 untagged vector: fault each time
    next_cycle(); set_wr(0, 32'h1002, 1, 0, 1); exp_rd(0, 32'h1000, 0, "R1 untag vec");
    next_cycle(); set_trap(32'h5200, 1, 5'h01, 5'd2, 0);
    exp_pcc(32'h1000, 0, 1, 32'h0000_0041, "R7 untagged vector fault");
    next_cycle(); exp_idle("R7 fault one cycle");
    next_cycle(); set_trap(32'h1000, 0, 5'h02, 5'd0, 1);
    exp_pcc(32'h1000, 0, 1, 32'h0000_0402, "R7 fault repeats");
    next_cycle(); mret_i = 1; exp_pcc(32'h1000, 0, 1, 32'h0000_0402, "R7 mret untagged epc");

    // R9 collisions
    next_cycle(); set_wr(0, 32'h8000, 1, 0, 1); exp_rd(0, 32'h8000, 1, "R4 vec restore");
    next_cycle(); set_wr(1, 32'h9000, 1, 0, 1); set_trap(32'h6000, 1, 5'h04, 5'd3, 0);
    mv_a = 32'h0000_0064;
    exp_pcc(32'h8000, 1, 0, mv_a, "R9 trap vs epc write"); exp_rd(1, 32'h6000, 1, "R9 save wins");
    next_cycle(); set_wr(0, 32'hA000, 1, 0, 1); set_trap(32'h6100, 1, 5'h04, 5'd3, 0);
    exp_pcc(32'h8000, 1, 0, mv_a, "R9 old vector used"); exp_rd(0, 32'hA000, 1, "R9 vec write lands");

    // R10 trap beats mret
    next_cycle(); set_trap(32'h7000, 1, 5'h05, 5'd1, 0); mret_i = 1;
    exp_pcc(32'hA000, 1, 0, 32'h0000_0025, "R10 trap priority");
    exp_rd(1, 32'h7000, 1, "R10 epc saved");
    next_cycle(); exp_idle("R10 idle after");
    next_cycle();
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R4", "pending expectations", q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule